// File: doc/BRIEF.md
# Stack Processor Arithmetic and Logic Unit

This block is the datapath arithmetic unit of a microcoded stack processor. Two 32-bit operands (the first normally the top of stack, the second a stack entry or an immediate) and a 4-bit operation code go in. The block returns a 32-bit result and a single status bit. The unit is purely combinational: the result follows the inputs within the same cycle, and the surrounding datapath registers it.

The operation set has sixteen entries. There are wrap-around add, subtract and negate, a one-cycle multiply that keeps the low word, bitwise logic, and a pass-through of the second operand. Shifting is done by a barrel shifter in two directions: left with zero fill, and right with sign fill. Comparisons give boolean words for signed less-than, unsigned less-than and equality. Two sign-extension operations widen a byte or a halfword. The status bit reports an all-zero result, and it drives the microcode sequencer's branch condition.

Top module: `stk_alu`

## Requirements
- R1: Operation codes on `op_sel`: 0 add, 1 subtract (`opnd_a - opnd_b`), 15 negate (`0 - opnd_a`). All arithmetic wraps modulo 2^32.
- R2: Code 2 multiplies the operands and returns the low 32 bits of the product in the same cycle.
- R3: Codes 3 AND, 4 OR, 5 XOR, 6 bitwise NOT of `opnd_a`, 7 passes `opnd_b` unchanged.
- R4: Code 8 shifts `opnd_a` left by `opnd_b[4:0]` and fills with zeros. Bits 31..5 of `opnd_b` are ignored.
- R5: Code 9 shifts `opnd_a` right by `opnd_b[4:0]` and fills with copies of `opnd_a[31]`.
- R6: Code 10 returns 32'h1 when `opnd_a < opnd_b` as two's-complement numbers, otherwise 32'h0.
- R7: Code 11 returns 32'h1 when `opnd_a < opnd_b` as unsigned numbers, otherwise 32'h0.
- R8: Code 12 returns 32'h1 when the operands are equal, otherwise 32'h0.
- R9: Code 13 sign-extends `opnd_a[7:0]` and code 14 sign-extends `opnd_a[15:0]` to 32 bits. The remaining bits of `opnd_a` have no effect.
- R10: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R11: The block has no clock or state. `result` and `zero` depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (shifted, extended, negated value) |
| opnd_b | input | 32 | Second operand (shift amount in bits 4..0) |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The hardest cases to reach are the ones where signed and unsigned comparisons give different answers. These need operands of opposite sign whose unsigned order is the reverse of their signed order. The other hard cases are at the edges of the shifter: full shift counts, and counts where only the ignored high bits of the second operand are set. Purely random operands almost never hit equality or a multiply product that wraps to zero. So the stimulus opens with directed vectors for those edges: a sign-bit-only operand, equal operands, 2^16 squared, and a count of 33 that must act as 1. Random vectors over all sixteen codes follow, and half of them reuse one operand for both inputs so that equality and zero results keep coming up.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_AND  = 4'h3,
        OP_OR   = 4'h4,
        OP_XOR  = 4'h5,
        OP_NOT  = 4'h6,
        OP_PASS = 4'h7,
        OP_SHL  = 4'h8,
        OP_SAR  = 4'h9,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB,
        OP_SEQ  = 4'hC,
        OP_SXB  = 4'hD,
        OP_SXH  = 4'hE,
        OP_NEG  = 4'hF
    } alu_op_e;

endpackage

// File: rtl/stk_alu_arith.sv
module stk_alu_arith #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o,
    output logic [W-1:0] neg_o,
    output logic [W-1:0] prod_o
);

    always_comb begin
        sum_o  = a + b;
        diff_o = a - b;
        neg_o  = '0 - a;
        prod_o = a * b;
    end

    // R1: subtracting back the addend recovers the first operand
    always_comb begin
        p_add_inverse_r1: assert ((sum_o - b) == a)
            else $error("add/sub inverse broken");
        // R2: multiply by one is identity
        if (b == W'(1)) begin
            p_mul_unit_r2: assert (prod_o == a)
                else $error("multiply by one altered operand");
        end
    end

endmodule

// File: rtl/stk_alu_logic.sv
module stk_alu_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] not_o,
    output logic [W-1:0] sxb_o,
    output logic [W-1:0] sxh_o
);

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;

    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        xor_o = a ^ b;
        not_o = ~a;
        sxb_o = {{(W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
        sxh_o = {{(W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
    end

    // R9: extended values keep the low field and agree with the shorter one
    always_comb begin
        p_sext_low_r9: assert (sxb_o[BYTE_W-1:0] == sxh_o[BYTE_W-1:0])
            else $error("sign extension low byte mismatch");
        // R3: xor equals or minus and, bitwise
        p_xor_split_r3: assert (xor_o == (or_o & ~and_o))
            else $error("logic ops inconsistent");
    end

endmodule

// File: rtl/stk_alu_shift.sv
module stk_alu_shift #(
    parameter int unsigned W = 32,
    localparam int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   shl_o,
    output logic [W-1:0]   sar_o
);

    logic [W-1:0] l_stg [SHW+1];
    logic [W-1:0] r_stg [SHW+1];

    assign l_stg[0] = a;
    assign r_stg[0] = a;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int unsigned STEP = 1 << i;
        assign l_stg[i+1] = amt[i] ? (l_stg[i] << STEP) : l_stg[i];
        assign r_stg[i+1] = amt[i] ? W'($signed(r_stg[i]) >>> STEP) : r_stg[i];
    end

    assign shl_o = l_stg[SHW];
    assign sar_o = r_stg[SHW];

    always_comb begin
        // R4 / R5: zero count leaves the operand untouched
        if (amt == '0) begin
            p_shift_zero_r4: assert (shl_o == a && sar_o == a)
                else $error("zero shift changed operand");
        end
        // R5: sign bit survives arithmetic right shift
        p_sar_sign_r5: assert (sar_o[W-1] == a[W-1])
            else $error("arithmetic shift lost sign");
    end

endmodule

// File: rtl/stk_alu_cmp.sv
module stk_alu_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt_s_o,
    output logic         lt_u_o,
    output logic         eq_o
);

    logic [W:0] wide_diff;

    always_comb begin
        wide_diff = {1'b0, a} - {1'b0, b};
        lt_u_o    = wide_diff[W];
        lt_s_o    = (a[W-1] != b[W-1]) ? a[W-1] : wide_diff[W-1];
        eq_o      = ~|(a ^ b);
    end

    always_comb begin
        // R6 / R7: same sign bit means signed and unsigned order agree
        if (a[W-1] == b[W-1]) begin
            p_order_agree_r7: assert (lt_s_o == lt_u_o)
                else $error("signed/unsigned order disagree");
        end
        // R8: equal operands are never less-than
        if (eq_o) begin
            p_eq_not_lt_r8: assert (!lt_s_o && !lt_u_o)
                else $error("equal operands flagged less-than");
        end
    end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_alu_pkg::*;
#(
    parameter int unsigned W = 32,
    localparam int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [OP_W-1:0] op_sel,
    output logic [W-1:0]    result,
    output logic            zero
);

    alu_op_e      op;
    logic [W-1:0] sum_w, diff_w, neg_w, prod_w;
    logic [W-1:0] and_w, or_w, xor_w, not_w, sxb_w, sxh_w;
    logic [W-1:0] shl_w, sar_w;
    logic         lt_s_w, lt_u_w, eq_w;
    logic [W-1:0] result_d;

    assign op = alu_op_e'(op_sel);

    stk_alu_arith #(.W(W)) u_arith (
        .a(opnd_a), .b(opnd_b),
        .sum_o(sum_w), .diff_o(diff_w), .neg_o(neg_w), .prod_o(prod_w)
    );

    stk_alu_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .and_o(and_w), .or_o(or_w), .xor_o(xor_w), .not_o(not_w),
        .sxb_o(sxb_w), .sxh_o(sxh_w)
    );

    stk_alu_shift #(.W(W)) u_shift (
        .a(opnd_a), .amt(opnd_b[SHW-1:0]),
        .shl_o(shl_w), .sar_o(sar_w)
    );

    stk_alu_cmp #(.W(W)) u_cmp (
        .a(opnd_a), .b(opnd_b),
        .lt_s_o(lt_s_w), .lt_u_o(lt_u_w), .eq_o(eq_w)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  result_d = sum_w;
            OP_SUB:  result_d = diff_w;
            OP_MUL:  result_d = prod_w;
            OP_AND:  result_d = and_w;
            OP_OR:   result_d = or_w;
            OP_XOR:  result_d = xor_w;
            OP_NOT:  result_d = not_w;
            OP_PASS: result_d = opnd_b;
            OP_SHL:  result_d = shl_w;
            OP_SAR:  result_d = sar_w;
            OP_SLT:  result_d = W'(lt_s_w);
            OP_SLTU: result_d = W'(lt_u_w);
            OP_SEQ:  result_d = W'(eq_w);
            OP_SXB:  result_d = sxb_w;
            OP_SXH:  result_d = sxh_w;
            OP_NEG:  result_d = neg_w;
            default: result_d = '0;
        endcase
    end

    assign result = result_d;
    assign zero   = ~|result_d;

    always_comb begin
        // R10: subtraction result is zero exactly when comparator sees equality
        if (op == OP_SUB) begin
            p_sub_zero_r10: assert (zero == eq_w)
                else $error("zero flag disagrees with equality");
        end
        // R6: comparison results are boolean words
        if (op == OP_SLT || op == OP_SLTU || op == OP_SEQ) begin
            p_cmp_bool_r6: assert (result[W-1:1] == '0)
                else $error("comparison result not boolean");
        end
    end

endmodule

// File: tb/test_stk_alu.sv
`timescale 1ns/1ps
module test_stk_alu;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] q_res [$];
    logic        q_zero [$];
    string       q_tag [$];

    always #(HALF) clk = ~clk;

    stk_alu i_stk_alu (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
        .result(result), .zero(zero)
    );

    function automatic logic [31:0] model(input logic [3:0] op,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        logic [63:0] p;
        case (op)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h2: begin p = {32'b0, a} * {32'b0, b}; return p[31:0]; end
            4'h3: return a & b;
            4'h4: return a | b;
            4'h5: return a ^ b;
            4'h6: return ~a;
            4'h7: return b;
            4'h8: return a << b[4:0];
            4'h9: return $unsigned($signed(a) >>> b[4:0]);
            4'hA: return ($signed(a) < $signed(b)) ? 32'h1 : 32'h0;
            4'hB: return (a < b) ? 32'h1 : 32'h0;
            4'hC: return (a == b) ? 32'h1 : 32'h0;
            4'hD: return {{24{a[7]}}, a[7:0]};
            4'hE: return {{16{a[15]}}, a[15:0]};
            default: return 32'h0 - a;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1, 4'hF: return "R1";
            4'h2: return "R2";
            4'h8: return "R4";
            4'h9: return "R5";
            4'hA: return "R6";
            4'hB: return "R7";
            4'hC: return "R8";
            4'hD, 4'hE: return "R9";
            default: return "R3";
        endcase
    endfunction

    // driver: apply one vector per cycle and queue its expected outcome
    task automatic drive(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] exp,
                         input string tag);
        @(posedge clk);
        #1;
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        q_res.push_back(exp);
        q_zero.push_back(exp == 32'h0);
        q_tag.push_back(tag);
    endtask

    // monitor: compare in the middle of the cycle
    always @(negedge clk) begin
        if (rst_n && q_res.size() > 0) begin
            logic [31:0] er;
            logic        ez;
            string       t;
            er = q_res.pop_front();
            ez = q_zero.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (result !== er) begin
                fails++;
                $display("FAIL %s result got %h exp %h", t, result, er);
            end
            checks++;
            if (zero !== ez) begin
                fails++;
                $display("FAIL R10 (%s) zero got %b exp %b", t, zero, ez);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R11 reset state: all-zero inputs, add -> zero result, flag high
        #1;
        checks++;
        if (result !== 32'h0 || zero !== 1'b1) begin
            fails++;
            $display("FAIL R11 idle got %h/%b exp 00000000/1", result, zero);
        end
        rst_n = 1'b1;

        drive(4'h0, 32'hFFFF_FFFF, 32'h1, 32'h0, "R1 add wrap");
        drive(4'h1, 32'h0, 32'h1, 32'hFFFF_FFFF, "R1 sub wrap");
        drive(4'hF, 32'h8000_0000, 32'h0, 32'h8000_0000, "R1 neg min");
        drive(4'hF, 32'h0000_0005, 32'h0, 32'hFFFF_FFFB, "R1 neg");
        drive(4'h2, 32'h0001_0000, 32'h0001_0000, 32'h0, "R2 mul wraps to zero");
        drive(4'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, "R2 mul low word");
        drive(4'h3, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h00F0_1234, "R3 and");
        drive(4'h6, 32'h0000_FFFF, 32'h1234_5678, 32'hFFFF_0000, "R3 not ignores b");
        drive(4'h7, 32'hDEAD_BEEF, 32'h0000_0042, 32'h0000_0042, "R3 pass b");
        drive(4'h8, 32'h8000_0001, 32'h0000_0021, 32'h0000_0002, "R4 high count bits ignored");
        drive(4'h8, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000, "R4 full shift");
        drive(4'h9, 32'h8000_0000, 32'h0000_001F, 32'hFFFF_FFFF, "R5 sign fill");
        drive(4'h9, 32'h4000_0000, 32'hFFFF_FFFE, 32'h0000_0001, "R5 positive");
        drive(4'hA, 32'hFFFF_FFFF, 32'h0000_0001, 32'h1, "R6 -1 < 1");
        drive(4'hA, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0, "R6 max vs min");
        drive(4'hB, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, "R7 unsigned");
        drive(4'hB, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1, "R7 unsigned across sign");
        drive(4'hC, 32'h1357_9BDF, 32'h1357_9BDF, 32'h1, "R8 equal");
        drive(4'hC, 32'h1357_9BDF, 32'h1357_9BDE, 32'h0, "R8 differ");
        drive(4'hD, 32'h1234_5680, 32'h0, 32'hFFFF_FF80, "R9 byte neg");
        drive(4'hD, 32'hFFFF_FF7F, 32'h0, 32'h0000_007F, "R9 byte upper ignored");
        drive(4'hE, 32'hABCD_7FFF, 32'h0, 32'h0000_7FFF, "R9 half pos");
        drive(4'hE, 32'h0000_8001, 32'h0, 32'hFFFF_8001, "R9 half neg");
        drive(4'h1, 32'h0BAD_F00D, 32'h0BAD_F00D, 32'h0, "R10 sub to zero");

        for (int k = 0; k < 600; k++) begin
            logic [3:0]  op;
            logic [31:0] a;
            logic [31:0] b;
            op = 4'(k % 16);
            a  = $urandom;
            b  = (k % 2 == 0) ? a : $urandom;
            if (k % 7 == 0) b = {27'($urandom), 5'(k)};
            drive(op, a, b, model(op, a, b), tag_of(op));
        end

        while (q_res.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule